// File: doc/BRIEF.md
# Frame-Synchronised DSP Program Controller

This block is the control front end of a small voice-path signal processor. A byte-wide host port reaches two hardware registers at all times: a receive gain register and an engine control register. The same port also reaches a small bank of parameter words: transmit PCM gain, transmit keypad-tone level, two tone/ringer coefficients and a ringer warble rate. These words can only be read or written while the engine is held halted by a bit in the control register. All other low addresses belong to the engine's scratch variables and are shielded from the host.

The control register carries a three-bit program select. A new select value does not take effect when it is written. It is picked up on the next single-cycle frame strobe, so every micro-program run starts on a frame boundary. Releasing the halt bit does not start the engine at once; execution starts at the following frame strobe. The block drives the active program code, a running flag, a transmit autonull enable, the receive gain byte and the parameter words to the arithmetic datapath, which lies outside this block.

Top module: `dsp_prog_ctrl`

## Requirements
- R1: After the asynchronous reset, prog_code is 000, dsp_running is 0, autonull_en is 0, and every register and parameter word reads and drives 00h.
- R2: The control register at address 1Eh is writable and readable at any time. Bit 7 is the halt bit. Bits 2:0 are the program select. Bits 6:3 are discarded on write and read as 0.
- R3: The receive gain register at address 1Dh is writable and readable at any time and keeps all 8 bits. Bit 7 is the AUTO (transmit autonull) bit. The byte is driven on rx_gain.
- R4: The parameter words sit at 20h (tx_pcm_gain), 21h (tx_tone_level), 23h (coef_a), 24h (coef_b) and 26h (warble_rate). While the halt bit is 0, host writes to them are ignored and reads return 00h. While the halt bit is 1, they read back what was written.
- R5: Writes to reserved addresses change nothing, and reads of them return 00h. Reserved addresses are every address below 20h other than 1Dh and 1Eh, plus 22h, 25h and 27h–3Fh.
- R6: The parameter outputs always present the stored words, whether the engine is halted or running.
- R7: With halt 0, prog_code takes the decoded select value in the cycle after a frame strobe is sampled. A select write between strobes leaves prog_code unchanged.
- R8: The cycle after the halt bit is seen set, dsp_running is 0 and prog_code is 000, and both stay so while halt is 1. After halt is cleared, dsp_running rises only in the cycle after the next frame strobe.
- R9: Select codes 100–111 run as program 000.
- R10: autonull_en is 1 exactly when dsp_running is 1, prog_code is not 000, and AUTO is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Single-cycle frame strobe (8 kHz) |
| host_wr | input | 1 | Host write strobe, sampled on the rising clock edge |
| host_addr | input | 6 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| prog_code | output | 3 | Active micro-program code |
| dsp_running | output | 1 | Engine running (1) or held / waiting for a frame strobe (0) |
| autonull_en | output | 1 | Transmit offset autonull enable |
| rx_gain | output | 8 | Receive gain register contents |
| tx_pcm_gain | output | 8 | Transmit PCM gain word |
| tx_tone_level | output | 8 | Transmit keypad-tone level word |
| coef_a | output | 8 | Tone/ringer coefficient A |
| coef_b | output | 8 | Tone/ringer coefficient B |
| warble_rate | output | 8 | Ringer warble rate word |

## Verification
A host write takes effect at the clock edge where it is sampled. Read data, rx_gain, the parameter outputs and autonull_en therefore settle within that same cycle and are checked on the following falling edge. The bench drives every stimulus on a falling edge and samples on the next falling edge. prog_code and dsp_running respond one edge after the frame strobe, so they are checked on the falling edge right after the strobe is removed. After a halt write, the bench waits one more cycle before checking, because the engine sees the halt bit only through the control register.

// File: rtl/dspc_pkg.sv
package dspc_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int NUM_PARAM = 5;
  localparam int IDX_W     = $clog2(NUM_PARAM);
  localparam int HALT_BIT  = 7;
  localparam int AUTO_BIT  = 7;
  localparam int SEL_W     = 3;

  localparam logic [ADDR_W-1:0] ADDR_RXGAIN = 6'h1D;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 6'h1E;
  localparam logic [ADDR_W-1:0] PARAM_ADDR [NUM_PARAM] =
    '{6'h20, 6'h21, 6'h23, 6'h24, 6'h26};

  typedef enum logic [SEL_W-1:0] {
    PROG_IDLE = 3'b000,
    PROG_GAIN = 3'b001,
    PROG_TONE = 3'b010,
    PROG_RING = 3'b011
  } prog_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pmap_t;

  function automatic pmap_t param_lookup(input logic [ADDR_W-1:0] a);
    pmap_t r;
    r = '0;
    for (int i = 0; i < NUM_PARAM; i++) begin
      if (a == PARAM_ADDR[i]) begin
        r.hit = 1'b1;
        r.idx = IDX_W'(i);
      end
    end
    return r;
  endfunction

  function automatic prog_e decode_sel(input logic [SEL_W-1:0] s);
    prog_e p;
    case (s)
      3'b001:  p = PROG_GAIN;
      3'b010:  p = PROG_TONE;
      3'b011:  p = PROG_RING;
      default: p = PROG_IDLE;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/dspc_host_regs.sv
module dspc_host_regs
  import dspc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          halt_o,
  output logic [SEL_W-1:0] sel_o,
  output logic          auto_o,
  output logic [DW-1:0] rx_gain_o,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << HALT_BIT) | ((1 << SEL_W) - 1));

  logic [DW-1:0] ctrl_q, rxg_q;
  logic          ctrl_wr, rxg_wr;

  assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
  assign rxg_wr  = wr_en && (addr == ADDR_RXGAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rxg_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata & CTRL_MASK;
      if (rxg_wr)  rxg_q  <= wdata;
    end
  end

  assign halt_o    = ctrl_q[HALT_BIT];
  assign sel_o     = ctrl_q[SEL_W-1:0];
  assign auto_o    = rxg_q[AUTO_BIT];
  assign rx_gain_o = rxg_q;

  always_comb begin
    rd_data_o = '0;
    if (addr == ADDR_CTRL)   rd_data_o = ctrl_q;
    if (addr == ADDR_RXGAIN) rd_data_o = rxg_q;
  end

  // R2
  ctrl_halt_tracks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (halt_o == $past(wdata[HALT_BIT])) && (sel_o == $past(wdata[SEL_W-1:0])));

  // R3
  rxg_stable_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxg_wr |=> $stable(rx_gain_o));
endmodule

// File: rtl/dspc_param_ram.sv
module dspc_param_ram
  import dspc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NP = NUM_PARAM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             halt_i,
  output logic [NP*DW-1:0] words_o,
  output logic [DW-1:0]    rd_data_o
);
  pmap_t         map;
  logic          host_open;
  logic [DW-1:0] word_q [NP];

  assign map       = param_lookup(addr);
  assign host_open = halt_i && map.hit;

  for (genvar g = 0; g < NP; g++) begin : g_word
    logic sel_wr;
    assign sel_wr = wr_en && host_open && (map.idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q[g] <= '0;
      else if (sel_wr) word_q[g] <= wdata;
    end

    assign words_o[g*DW +: DW] = word_q[g];

    // R4
    locked_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !halt_i |=> $stable(word_q[g]));
  end

  assign rd_data_o = host_open ? word_q[map.idx] : '0;
endmodule

// File: rtl/dspc_prog_seq.sv
module dspc_prog_seq
  import dspc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_i,
  input  logic             halt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             auto_i,
  output logic [SEL_W-1:0] prog_o,
  output logic             run_o,
  output logic             autonull_o
);
  prog_e prog_q;
  logic  run_q;
  logic  frame_start;

  assign frame_start = fp_i && !halt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= PROG_IDLE;
      run_q  <= 1'b0;
    end else if (halt_i) begin
      prog_q <= PROG_IDLE;
      run_q  <= 1'b0;
    end else if (frame_start) begin
      prog_q <= decode_sel(sel_i);
      run_q  <= 1'b1;
    end
  end

  assign prog_o     = prog_q;
  assign run_o      = run_q;
  assign autonull_o = run_q && (prog_q != PROG_IDLE) && auto_i;

  // R7
  prog_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_i && !halt_i) |=> $stable(prog_o));

  // R8
  start_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_i |=> !$rose(run_o));

  // R8
  halt_stops_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (!run_o && prog_o == PROG_IDLE));

  // R9
  no_undefined_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_o[SEL_W-1]);
endmodule

// File: rtl/dsp_prog_ctrl.sv
module dsp_prog_ctrl
  import dspc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [SEL_W-1:0]  prog_code,
  output logic              dsp_running,
  output logic              autonull_en,
  output logic [DATA_W-1:0] rx_gain,
  output logic [DATA_W-1:0] tx_pcm_gain,
  output logic [DATA_W-1:0] tx_tone_level,
  output logic [DATA_W-1:0] coef_a,
  output logic [DATA_W-1:0] coef_b,
  output logic [DATA_W-1:0] warble_rate
);
  logic                      halt, auto_bit;
  logic [SEL_W-1:0]          sel;
  logic [DATA_W-1:0]         reg_rd, ram_rd;
  logic [NUM_PARAM*DATA_W-1:0] words;

  dspc_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr), .wdata(host_wdata),
    .halt_o(halt), .sel_o(sel), .auto_o(auto_bit), .rx_gain_o(rx_gain), .rd_data_o(reg_rd)
  );

  dspc_param_ram u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr), .wdata(host_wdata),
    .halt_i(halt), .words_o(words), .rd_data_o(ram_rd)
  );

  dspc_prog_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fp_i(frame_pulse), .halt_i(halt), .sel_i(sel),
    .auto_i(auto_bit), .prog_o(prog_code), .run_o(dsp_running), .autonull_o(autonull_en)
  );

  assign host_rdata    = reg_rd | ram_rd;
  assign tx_pcm_gain   = words[0*DATA_W +: DATA_W];
  assign tx_tone_level = words[1*DATA_W +: DATA_W];
  assign coef_a        = words[2*DATA_W +: DATA_W];
  assign coef_b        = words[3*DATA_W +: DATA_W];
  assign warble_rate   = words[4*DATA_W +: DATA_W];

  // R10
  autonull_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    autonull_en |-> dsp_running);

  // R5
  reserved_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr < 6'h20 && host_addr != ADDR_CTRL && host_addr != ADDR_RXGAIN) |-> host_rdata == '0);
endmodule

// File: tb/dsp_prog_ctrl_bench.sv
module dsp_prog_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, frame_pulse = 1'b0, host_wr = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, rx_gain, tx_pcm_gain, tx_tone_level, coef_a, coef_b, warble_rate;
  logic [2:0] prog_code;
  logic       dsp_running, autonull_en;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_prog_ctrl u_dsp_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .prog_code(prog_code), .dsp_running(dsp_running), .autonull_en(autonull_en),
    .rx_gain(rx_gain), .tx_pcm_gain(tx_pcm_gain), .tx_tone_level(tx_tone_level),
    .coef_a(coef_a), .coef_b(coef_b), .warble_rate(warble_rate)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    host_addr = a;
    #1;
    chk(req, host_rdata, exp);
  endtask

  task automatic pulse();
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 prog", {5'b0, prog_code}, 8'h00);
    chk("R1 run", {7'b0, dsp_running}, 8'h00);
    chk("R1 autonull", {7'b0, autonull_en}, 8'h00);
    chk("R1 params", tx_pcm_gain | tx_tone_level | coef_a | coef_b | warble_rate, 8'h00);
    rd_chk("R1 ctrl", 6'h1E, 8'h00);
    rd_chk("R1 rxgain", 6'h1D, 8'h00);
  endtask

  task automatic t_ctrl_and_frame();
    pulse();
    chk("R8 start at frame", {7'b0, dsp_running}, 8'h01);
    wr(6'h1E, 8'h7A);
    rd_chk("R2 ctrl masked", 6'h1E, 8'h02);
    chk("R7 no change before frame", {5'b0, prog_code}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 still waiting", {5'b0, prog_code}, 8'h00);
    pulse();
    chk("R7 prog at frame", {5'b0, prog_code}, 8'h02);
    wr(6'h1D, 8'h85);
    rd_chk("R3 rxgain readback", 6'h1D, 8'h85);
    chk("R3 rx_gain port", rx_gain, 8'h85);
    chk("R10 autonull on", {7'b0, autonull_en}, 8'h01);
    wr(6'h1D, 8'h05);
    chk("R10 autonull off", {7'b0, autonull_en}, 8'h00);
  endtask

  task automatic t_locked();
    wr(6'h20, 8'h33);
    chk("R4 locked write ignored", tx_pcm_gain, 8'h00);
    rd_chk("R4 locked read zero", 6'h20, 8'h00);
  endtask

  task automatic t_halt_params();
    wr(6'h1E, 8'h80);
    @(negedge clk);
    chk("R8 halted run", {7'b0, dsp_running}, 8'h00);
    chk("R8 halted prog", {5'b0, prog_code}, 8'h00);
    rd_chk("R2 halt readback", 6'h1E, 8'h80);
    wr(6'h20, 8'h11); wr(6'h21, 8'h22); wr(6'h23, 8'h33);
    wr(6'h24, 8'h44); wr(6'h26, 8'h55);
    chk("R6 tx_pcm_gain", tx_pcm_gain, 8'h11);
    chk("R6 tx_tone_level", tx_tone_level, 8'h22);
    chk("R6 coef_a", coef_a, 8'h33);
    chk("R6 coef_b", coef_b, 8'h44);
    chk("R6 warble_rate", warble_rate, 8'h55);
    rd_chk("R4 read 21h", 6'h21, 8'h22);
    rd_chk("R4 read 26h", 6'h26, 8'h55);
    pulse();
    chk("R8 frame while halted", {7'b0, dsp_running}, 8'h00);
  endtask

  task automatic t_reserved();
    wr(6'h22, 8'h99); rd_chk("R5 read 22h", 6'h22, 8'h00);
    wr(6'h25, 8'h99); rd_chk("R5 read 25h", 6'h25, 8'h00);
    wr(6'h27, 8'h99); rd_chk("R5 read 27h", 6'h27, 8'h00);
    wr(6'h10, 8'hAA); rd_chk("R5 read 10h", 6'h10, 8'h00);
    wr(6'h1F, 8'hAA); rd_chk("R5 read 1Fh", 6'h1F, 8'h00);
    rd_chk("R5 ctrl untouched", 6'h1E, 8'h80);
    rd_chk("R5 rxgain untouched", 6'h1D, 8'h05);
    chk("R5 params untouched", tx_pcm_gain ^ tx_tone_level ^ coef_a ^ coef_b ^ warble_rate,
        8'h11 ^ 8'h22 ^ 8'h33 ^ 8'h44 ^ 8'h55);
  endtask

  task automatic t_release();
    wr(6'h1E, 8'h03);
    @(negedge clk);
    chk("R8 no start before frame", {7'b0, dsp_running}, 8'h00);
    repeat (4) @(negedge clk);
    chk("R8 still waiting", {7'b0, dsp_running}, 8'h00);
    rd_chk("R4 locked again", 6'h24, 8'h00);
    pulse();
    chk("R8 run after frame", {7'b0, dsp_running}, 8'h01);
    chk("R7 prog ringer", {5'b0, prog_code}, 8'h03);
    chk("R6 params while running", coef_b, 8'h44);
    wr(6'h1D, 8'h80);
    chk("R10 autonull ringer", {7'b0, autonull_en}, 8'h01);
  endtask

  task automatic t_codes();
    wr(6'h1E, 8'h06);
    chk("R7 held until frame", {5'b0, prog_code}, 8'h03);
    pulse();
    chk("R9 code 110 idle", {5'b0, prog_code}, 8'h00);
    chk("R9 still running", {7'b0, dsp_running}, 8'h01);
    chk("R10 no autonull idle prog", {7'b0, autonull_en}, 8'h00);
    wr(6'h1E, 8'h05);
    pulse();
    chk("R9 code 101 idle", {5'b0, prog_code}, 8'h00);
    wr(6'h1E, 8'h01);
    pulse();
    chk("R7 prog gain", {5'b0, prog_code}, 8'h01);
    chk("R10 autonull gain", {7'b0, autonull_en}, 8'h01);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_and_frame();
    t_locked();
    t_halt_params();
    t_reserved();
    t_release();
    t_codes();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule